// File: doc/BRIEF.md
# Routing Track Selector with Optional Constant Source

This block sits between a set of 16-bit routing tracks and one consumer input. It picks one source and drives it combinationally onto a single output. The sources are the tracks that exist plus, if chosen at build time, a constant. The choice is held in one select register. That register is written and read back through a 32-bit configuration address and data port.

A per-track presence mask, given as a parameter, decides which track slots have a real input. A slot that is masked out has no effect on the output. Selecting it gives the fill value instead: the constant when the constant source is built in, and zero otherwise. The constant source sits at index `NUM_TRK`, one past the last track. Any select value above the last valid source index also gives the fill value.

Only the select register is clocked. The path from the tracks to the output has no register.

Top module: `cb_track_sel`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears the select register to 0. After it, `cb_out` shows track 0 and readback at address 0 returns 0.
- R2: A write with `cfg_we` high and `cfg_addr` equal to 0 stores the low `SEL_W` bits of `cfg_wdata` at the rising edge. With the defaults `SEL_W` is 4, so a write of 0x27 stores 7. The output keeps the old selection until that edge and changes right after it.
- R3: A write to any address other than 0, or a cycle with `cfg_we` low, leaves the select register and the output unchanged.
- R4: `cfg_rdata` is combinational. It is the stored select value zero-extended to 32 bits when `cfg_addr` is 0, and 0 for any other address.
- R5: When the select value is the index i of a present track, `cb_out` equals bits [16i+15:16i] of `trk_in`. It follows changes on that slice with no clock edge.
- R6: Track 5 is masked out by the default mask (bit i of `TRK_MASK` set means track i exists). Selecting index 5 drives the fill value, and bits [95:80] of `trk_in` have no effect on `cb_out`.
- R7: With `HAS_CONST` set, select value `NUM_TRK` (10) drives `CONST_VAL`, which defaults to 0xA5C3.
- R8: Select values above the last source index (11 to 15 with the defaults) drive the fill value.
- R9: When reset and an address-0 write occur in the same cycle, the reset wins and the register holds 0.
- R10: With `HAS_CONST` clear, the fill value is 0. This holds for index 10, for masked tracks and for out-of-range values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 32 | Configuration address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration readback |
| trk_in | input | NUM_TRK*DATA_W | Track inputs, track i in bits [DATA_W*i+DATA_W-1:DATA_W*i] |
| cb_out | output | DATA_W | Selected source |

## Verification
Three things can meet in one cycle.

A configuration write and the combinational data path meet in the write cycle itself. In that cycle the output must still show the old selection. The bench checks this a moment after the inputs are driven and again just after the edge, and it expects the new source only in the second sample.

Reset and an address-0 write are also driven together in one cycle. The expected value is a select of 0 and track 0 on the output.

Finally, the track inputs are changed with no clock edge while a present track is selected, and then while the masked track is selected. This shows both that the output follows a selected track at once and that the masked slice is ignored.

// File: rtl/cb_pkg.sv
package cb_pkg;
   localparam int unsigned CFG_W = 32;

   // Bits needed to encode n distinct values (at least one).
   function automatic int unsigned enc_bits(input int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cb_cfg_reg.sv
module cb_cfg_reg #(
   parameter int unsigned SEL_W  = 4,
   parameter int unsigned CFG_W  = 32,
   parameter int unsigned REG_AD = 0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [CFG_W-1:0] cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   output logic [SEL_W-1:0] sel_q,
   output logic [CFG_W-1:0] rd_data
);
   localparam logic [CFG_W-1:0] AD = CFG_W'(REG_AD);

   logic hit;
   logic unused_wdata_hi;

   assign hit             = (cfg_addr == AD);
   assign unused_wdata_hi = ^cfg_wdata;

   always_ff @(posedge clk) begin
      if (rst)                sel_q <= '0;
      else if (cfg_we && hit) sel_q <= cfg_wdata[SEL_W-1:0];
   end

   assign rd_data = hit ? CFG_W'(sel_q) : '0;

   AST_RST_ZERO: assert property (@(posedge clk) rst |=> sel_q == '0) else $error("reset"); // R1
   AST_WR_LOAD:  assert property (@(posedge clk) disable iff (rst)
                    (cfg_we && cfg_addr == AD) |=> sel_q == $past(cfg_wdata[SEL_W-1:0])) else $error("load"); // R2
   AST_NO_WR_HOLD: assert property (@(posedge clk) disable iff (rst)
                    !(cfg_we && cfg_addr == AD) |=> $stable(sel_q)) else $error("hold"); // R3
endmodule

// File: rtl/cb_src_map.sv
module cb_src_map #(
   parameter int unsigned            DATA_W  = 16,
   parameter int unsigned            NUM_TRK = 10,
   parameter int unsigned            NSRC    = 11,
   parameter logic [NUM_TRK-1:0]     TRK_MASK = '1,
   parameter logic [DATA_W-1:0]      FILL    = '0
) (
   input  logic [NUM_TRK*DATA_W-1:0]        trk_in,
   output logic [NSRC-1:0][DATA_W-1:0]      src
);
   for (genvar i = 0; i < NUM_TRK; i++) begin : g_trk
      if (TRK_MASK[i]) begin : g_present
         assign src[i] = trk_in[i*DATA_W +: DATA_W];
      end else begin : g_absent
         logic unused_slice;
         assign unused_slice = ^trk_in[i*DATA_W +: DATA_W];
         assign src[i] = FILL;
      end
   end
   if (NSRC > NUM_TRK) begin : g_const
      assign src[NUM_TRK] = FILL;
   end
endmodule

// File: rtl/cb_sel_mux.sv
module cb_sel_mux #(
   parameter int unsigned       DATA_W  = 16,
   parameter int unsigned       NSRC    = 11,
   parameter int unsigned       SEL_W   = 4,
   parameter int unsigned       NUM_TRK = 10,
   parameter bit                HAS_CONST = 1'b1,
   parameter logic [DATA_W-1:0] FILL    = '0
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic [SEL_W-1:0]            sel,
   input  logic [NSRC-1:0][DATA_W-1:0] src,
   output logic [DATA_W-1:0]           mux_o
);
   always_comb begin
      mux_o = FILL;
      for (int k = 0; k < NSRC; k++) begin
         if (sel == SEL_W'(k)) mux_o = src[k];
      end
   end

   AST_OOR_FILL: assert property (@(posedge clk) disable iff (rst)
                    (32'(sel) >= NSRC) |-> mux_o == FILL) else $error("oor"); // R8
   if (HAS_CONST) begin : g_chk_const
      AST_CONST_IDX: assert property (@(posedge clk) disable iff (rst)
                       (32'(sel) == NUM_TRK) |-> mux_o == FILL) else $error("const"); // R7
   end else begin : g_chk_zero
      AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
                       (32'(sel) >= NUM_TRK) |-> mux_o == '0) else $error("zero"); // R10
   end
endmodule

// File: rtl/cb_track_sel.sv
module cb_track_sel #(
   parameter int unsigned        DATA_W    = 16,
   parameter int unsigned        NUM_TRK   = 10,
   parameter logic [NUM_TRK-1:0] TRK_MASK  = 10'b11_1101_1111,
   parameter bit                 HAS_CONST = 1'b1,
   parameter logic [DATA_W-1:0]  CONST_VAL = 16'hA5C3
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cfg_we,
   input  logic [31:0]               cfg_addr,
   input  logic [31:0]               cfg_wdata,
   output logic [31:0]               cfg_rdata,
   input  logic [NUM_TRK*DATA_W-1:0] trk_in,
   output logic [DATA_W-1:0]         cb_out
);
   import cb_pkg::*;

   localparam int unsigned       NSRC  = NUM_TRK + (HAS_CONST ? 1 : 0);
   localparam int unsigned       SEL_W = enc_bits(NSRC);
   localparam logic [DATA_W-1:0] FILL  = HAS_CONST ? CONST_VAL : '0;

   if (DATA_W < 1 || NUM_TRK < 1) begin : g_bad_size
      $error("cb_track_sel: DATA_W and NUM_TRK must be positive");
   end
   if (SEL_W > CFG_W) begin : g_bad_sel
      $error("cb_track_sel: select field wider than config data");
   end

   logic [SEL_W-1:0]            sel_q;
   logic [NSRC-1:0][DATA_W-1:0] src;

   cb_cfg_reg #(.SEL_W(SEL_W), .CFG_W(CFG_W), .REG_AD(0)) cfg_i (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .sel_q(sel_q), .rd_data(cfg_rdata));

   cb_src_map #(.DATA_W(DATA_W), .NUM_TRK(NUM_TRK), .NSRC(NSRC),
                .TRK_MASK(TRK_MASK), .FILL(FILL)) map_i (
      .trk_in(trk_in), .src(src));

   cb_sel_mux #(.DATA_W(DATA_W), .NSRC(NSRC), .SEL_W(SEL_W), .NUM_TRK(NUM_TRK),
                .HAS_CONST(HAS_CONST), .FILL(FILL)) mux_i (
      .clk(clk), .rst(rst), .sel(sel_q), .src(src), .mux_o(cb_out));

   AST_RDBK: assert property (@(posedge clk) disable iff (rst)
                (cfg_addr == 32'd0) |-> cfg_rdata == 32'(sel_q)) else $error("rdbk"); // R4
   AST_RDBK_OTHER: assert property (@(posedge clk) disable iff (rst)
                (cfg_addr != 32'd0) |-> cfg_rdata == 32'd0) else $error("rdbk0"); // R4

   for (genvar i = 0; i < NUM_TRK; i++) begin : g_chk
      if (TRK_MASK[i]) begin : g_p
         AST_TRK_FOLLOW: assert property (@(posedge clk) disable iff (rst)
                (32'(sel_q) == i) |-> cb_out == trk_in[i*DATA_W +: DATA_W]) else $error("follow"); // R5
      end else begin : g_m
         AST_MASKED_FILL: assert property (@(posedge clk) disable iff (rst)
                (32'(sel_q) == i) |-> cb_out == FILL) else $error("masked"); // R6
      end
   end
endmodule

// File: tb/cb_track_sel_tb.sv
module cb_track_sel_tb_top;
   localparam logic [9:0]  MASK  = 10'b11_1101_1111;
   localparam logic [15:0] CONSTV = 16'hA5C3;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [159:0] trk_in = '0;
   logic [31:0] cfg_rdata, rd_nc;
   logic [15:0] cb_out, out_nc;

   always #5 clk = ~clk;

   cb_track_sel dut_i (.clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trk_in(trk_in), .cb_out(cb_out));
   cb_track_sel #(.HAS_CONST(1'b0)) dut_nc (.clk(clk), .rst(rst), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(rd_nc), .trk_in(trk_in),
      .cb_out(out_nc));

   typedef struct {
      string       req;
      logic [15:0] out_e;
      logic [15:0] nc_e;
      logic [31:0] rd_e;
   } exp_t;

   exp_t q[$];
   event ev;
   int   n_chk = 0;
   int   n_fail = 0;
   logic [3:0] ms = '0;
   bit   done = 1'b0;

   function automatic logic [15:0] exp_out(input logic [3:0] s, input bit hc);
      if (s < 4'd10 && MASK[s]) return trk_in[s*16 +: 16];
      return hc ? CONSTV : 16'h0;
   endfunction

   task automatic set_trk(input logic [15:0] seed);
      for (int i = 0; i < 10; i++) trk_in[i*16 +: 16] = seed ^ (16'h0F1E * 16'(i + 1));
   endtask

   task automatic push(input string req);
      exp_t e;
      e.req   = req;
      e.out_e = exp_out(ms, 1'b1);
      e.nc_e  = exp_out(ms, 1'b0);
      e.rd_e  = (cfg_addr == 32'd0) ? {28'd0, ms} : 32'd0;
      q.push_back(e);
      ->ev;
      #1;
   endtask

   // monitor
   initial begin
      forever begin
         @(ev);
         while (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_chk++;
            if (cb_out !== e.out_e || cfg_rdata !== e.rd_e || out_nc !== e.nc_e) begin
               n_fail++;
               $display("FAIL %s: out=%h rd=%h nc=%h expected out=%h rd=%h nc=%h",
                        e.req, cb_out, cfg_rdata, out_nc, e.out_e, e.rd_e, e.nc_e);
            end
         end
      end
   end

   // driver: one clock cycle, checked before and after the edge
   task automatic step(input bit r, input bit we, input logic [31:0] ad,
                       input logic [31:0] wd, input string req);
      @(negedge clk);
      rst = r; cfg_we = we; cfg_addr = ad; cfg_wdata = wd;
      #1;
      push({req, " pre-edge"});
      @(posedge clk);
      if (r) ms = '0;
      else if (we && ad == 32'd0) ms = wd[3:0];
      #2;
      push({req, " post-edge"});
   endtask

   function automatic string req_of(input int v);
      if (v == 5)  return "R6/R10 masked";
      if (v == 10) return "R7/R10 const idx";
      if (v > 10)  return "R8/R10 out of range";
      return "R5 present track";
   endfunction

   initial begin
      set_trk(16'h1234);
      step(1'b1, 1'b0, 32'd0, 32'd0, "R1 reset");
      step(1'b1, 1'b1, 32'd0, 32'd3, "R9 reset beats write");
      step(1'b0, 1'b0, 32'd0, 32'd0, "R1 reset state");
      for (int v = 0; v < 16; v++) begin
         set_trk(16'h1234 + 16'(v * 16'h0371));
         step(1'b0, 1'b1, 32'd0, 32'(v), {"R2 write, ", req_of(v)});
      end
      step(1'b0, 1'b1, 32'd0, 32'h27, "R2 truncation 0x27->7");
      step(1'b0, 1'b1, 32'd4, 32'd2, "R3 other address ignored, R4 readback 0");
      step(1'b0, 1'b0, 32'd0, 32'd2, "R3 no strobe ignored");
      step(1'b0, 1'b1, 32'd0, 32'd3, "R2 select 3");
      @(negedge clk);
      set_trk(16'hBEEF);
      #1 push("R5 combinational follow");
      step(1'b0, 1'b1, 32'd0, 32'd5, "R6 select masked");
      @(negedge clk);
      trk_in[80 +: 16] = ~trk_in[80 +: 16];
      #1 push("R6 masked slice ignored");
      step(1'b0, 1'b0, 32'd1, 32'd0, "R4 readback other addr");
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: run hung, actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule